// File: doc/BRIEF.md
# Execute Redirect Priority Selector

This block sits after the execute stage of an out-of-order core. Each clock cycle is one execute group: up to `LANES` resolved instructions, lane 0 the oldest, each tagged with its thread. For every thread the block picks the first instruction in the group that has to redirect the front end. It then registers one squash record for that thread, to be sent toward commit.

Three causes can raise a redirect. The first is a branch mispredict carried on the instruction itself. The second is a pending memory-order violation held per thread. The third is a blocked load that has not yet been handled, also per thread. Each cause fills the record in its own way: the redirect target, the mispredict and taken flags, and whether the instruction itself is part of the squash.

The block keeps the violation and load-handled state for each thread. It also counts the mispredicts that produce a redirect, split by whether the branch had been predicted taken.

Top module: `exec_redirect_sel`

## Requirements
- R1: During and right after reset, every `recValid` bit is 0, both counters are 0 and no violation is pending.
- R2: For each thread, only the oldest qualifying instruction in a group (lowest lane index) raises a record. Later instructions of that thread in the same group cause nothing. Threads are independent of each other.
- R3: For one instruction the causes rank as follows: mispredict first, then pending violation, then a blocked load that is not yet handled. Only the winning cause is consumed.
- R4: A mispredict record carries the instruction's sequence number, target = its next PC, `recMispPc` = its PC, `recBrMisp`=1 and `recInclSelf`=0.
- R5: In a mispredict record, `recBrTaken` is 1 exactly when next PC differs from PC + 4.
- R6: A violation record carries the instruction's sequence number, target = its next PC, `recBrMisp`=0 and `recInclSelf`=0. Raising it clears the thread's pending violation, so a later group does not repeat it.
- R7: A blocked-load record carries target = the instruction's own PC and `recInclSelf`=1, and marks the load handled. No further blocked-load record is raised for the thread until `ldBlocked` has been low for at least one cycle and then rises again.
- R8: Lanes with `laneSquashed`=1 never raise a record and consume no state, even when their mispredict bit is set.
- R9: Each mispredict record increments `cntTakenWrong` if the lane's predicted-taken bit was 1, and `cntNotTakenWrong` otherwise, in the same cycle the record appears.
- R10: A record is visible for exactly the cycle after its group; a group with no event gives `recValid`=0 for that thread.
- R11: A `violSet` pulse makes the violation pending from the next cycle on. The pending violation stays until an unsquashed instruction of that thread consumes it, however many groups pass without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneValid | input | LANES | Lane carries a resolved instruction |
| laneThread | input | LANES*TID_W | Thread of each lane |
| laneSquashed | input | LANES | Lane instruction already squashed |
| laneSeq | input | LANES*SEQ_W | Sequence number per lane |
| lanePc | input | LANES*PC_W | PC per lane |
| laneNextPc | input | LANES*PC_W | Resolved next PC per lane |
| lanePredTaken | input | LANES | Branch had been predicted taken |
| laneMispred | input | LANES | Branch resolved as mispredicted |
| violSet | input | THREADS | Pulse: memory-order violation detected for thread |
| ldBlocked | input | THREADS | Level: a load of the thread is blocked |
| recValid | output | THREADS | Squash record valid (one cycle) |
| recSeq | output | THREADS*SEQ_W | Squashing sequence number |
| recTarget | output | THREADS*PC_W | Redirect PC |
| recMispPc | output | THREADS*PC_W | Mispredicted branch PC |
| recBrMisp | output | THREADS | Record caused by a branch mispredict |
| recBrTaken | output | THREADS | Mispredicted branch was actually taken |
| recInclSelf | output | THREADS | The instruction itself is squashed too |
| cntTakenWrong | output | CNT_W | Count of predicted-taken mispredicts |
| cntNotTakenWrong | output | CNT_W | Count of predicted-not-taken mispredicts |

## Verification
The bench builds the block with its defaults: two threads, four lanes, 16-bit sequence numbers and 32-bit PCs. With two threads it can put both threads into one group, so the scans for each thread run at the same time and each thread's first-event latch can be checked separately. Four lanes leave room for a squashed older lane, a winning lane and a later losing lane of the same thread in one group. Those are the corner cases R2 and R8 depend on.

// File: rtl/exec_redirect_pkg.sv
package exec_redirect_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MISP = 2'd1,
    CAUSE_VIOL = 2'd2,
    CAUSE_BLK  = 2'd3
  } cause_e;

  typedef struct packed {
    logic   fire;
    cause_e cause;
  } redirStrobe_t;

endpackage

// File: rtl/exec_redirect_ctrl.sv
module exec_redirect_ctrl
  import exec_redirect_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int LANES   = 4,
  parameter int TID_W   = 1,
  parameter int LSEL_W  = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [LANES-1:0]                  laneValid,
  input  logic [LANES-1:0][TID_W-1:0]       laneThread,
  input  logic [LANES-1:0]                  laneSquashed,
  input  logic [LANES-1:0]                  laneMispred,
  input  logic [THREADS-1:0]                violSet,
  input  logic [THREADS-1:0]                ldBlocked,
  output redirStrobe_t [THREADS-1:0]        strb,
  output logic [THREADS-1:0][LSEL_W-1:0]    laneSel
);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic        violPend;
    logic        ldHandled;
    logic        claimed;
    cause_e      cause;
    logic [LSEL_W-1:0] sel;

    // Oldest-first scan; the first lane of this thread with any event wins.
    always_comb begin
      claimed = 1'b0;
      cause   = CAUSE_NONE;
      sel     = '0;
      for (int l = 0; l < LANES; l++) begin
        if (!claimed && laneValid[l] && !laneSquashed[l] &&
            (laneThread[l] == TID_W'(t))) begin
          if (laneMispred[l]) begin
            cause   = CAUSE_MISP;
            claimed = 1'b1;
            sel     = LSEL_W'(l);
          end else if (violPend) begin
            cause   = CAUSE_VIOL;
            claimed = 1'b1;
            sel     = LSEL_W'(l);
          end else if (ldBlocked[t] && !ldHandled) begin
            cause   = CAUSE_BLK;
            claimed = 1'b1;
            sel     = LSEL_W'(l);
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        violPend  <= 1'b0;
        ldHandled <= 1'b0;
      end else begin
        violPend  <= violSet[t] | (violPend & ~(cause == CAUSE_VIOL));
        ldHandled <= ldBlocked[t] & (ldHandled | (cause == CAUSE_BLK));
      end
    end

    assign strb[t].fire  = claimed;
    assign strb[t].cause = cause;
    assign laneSel[t]    = sel;
  end

endmodule

// File: rtl/exec_redirect_dp.sv
module exec_redirect_dp
  import exec_redirect_pkg::*;
#(
  parameter int THREADS    = 2,
  parameter int LANES      = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int CNT_W      = 16,
  parameter int INSN_BYTES = 4,
  parameter int LSEL_W     = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [LANES-1:0][SEQ_W-1:0]       laneSeq,
  input  logic [LANES-1:0][PC_W-1:0]        lanePc,
  input  logic [LANES-1:0][PC_W-1:0]        laneNextPc,
  input  logic [LANES-1:0]                  lanePredTaken,
  input  redirStrobe_t [THREADS-1:0]        strb,
  input  logic [THREADS-1:0][LSEL_W-1:0]    laneSel,
  output logic [THREADS-1:0]                recValid,
  output logic [THREADS-1:0][SEQ_W-1:0]     recSeq,
  output logic [THREADS-1:0][PC_W-1:0]      recTarget,
  output logic [THREADS-1:0][PC_W-1:0]      recMispPc,
  output logic [THREADS-1:0]                recBrMisp,
  output logic [THREADS-1:0]                recBrTaken,
  output logic [THREADS-1:0]                recInclSelf,
  output logic [CNT_W-1:0]                  cntTakenWrong,
  output logic [CNT_W-1:0]                  cntNotTakenWrong
);

  localparam int INC_W = $clog2(THREADS + 1);

  logic [THREADS-1:0] misTk;
  logic [THREADS-1:0] misNt;

  for (genvar t = 0; t < THREADS; t++) begin : g_rec
    logic [SEQ_W-1:0] seqS;
    logic [PC_W-1:0]  pcS;
    logic [PC_W-1:0]  npcS;
    logic             ptS;
    logic             vld, brm, tk, incl;
    logic [SEQ_W-1:0] seqR;
    logic [PC_W-1:0]  tgtR, mpcR;

    assign seqS = laneSeq[laneSel[t]];
    assign pcS  = lanePc[laneSel[t]];
    assign npcS = laneNextPc[laneSel[t]];
    assign ptS  = lanePredTaken[laneSel[t]];

    assign misTk[t] = strb[t].fire && (strb[t].cause == CAUSE_MISP) && ptS;
    assign misNt[t] = strb[t].fire && (strb[t].cause == CAUSE_MISP) && !ptS;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld  <= 1'b0;
        seqR <= '0;
        tgtR <= '0;
        mpcR <= '0;
        brm  <= 1'b0;
        tk   <= 1'b0;
        incl <= 1'b0;
      end else begin
        vld  <= strb[t].fire;
        seqR <= strb[t].fire ? seqS : '0;
        mpcR <= '0;
        brm  <= 1'b0;
        tk   <= 1'b0;
        incl <= 1'b0;
        tgtR <= '0;
        if (strb[t].fire) begin
          unique case (strb[t].cause)
            CAUSE_MISP: begin
              tgtR <= npcS;
              mpcR <= pcS;
              brm  <= 1'b1;
              tk   <= (npcS != (pcS + PC_W'(INSN_BYTES)));
            end
            CAUSE_VIOL: tgtR <= npcS;
            CAUSE_BLK: begin
              tgtR <= pcS;
              incl <= 1'b1;
            end
            default: tgtR <= '0;
          endcase
        end
      end
    end

    assign recValid[t]    = vld;
    assign recSeq[t]      = seqR;
    assign recTarget[t]   = tgtR;
    assign recMispPc[t]   = mpcR;
    assign recBrMisp[t]   = brm;
    assign recBrTaken[t]  = tk;
    assign recInclSelf[t] = incl;
  end

  logic [INC_W-1:0] incTk, incNt;

  always_comb begin
    incTk = '0;
    incNt = '0;
    for (int t = 0; t < THREADS; t++) begin
      incTk = incTk + INC_W'(misTk[t]);
      incNt = incNt + INC_W'(misNt[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntTakenWrong    <= '0;
      cntNotTakenWrong <= '0;
    end else begin
      cntTakenWrong    <= cntTakenWrong + CNT_W'(incTk);
      cntNotTakenWrong <= cntNotTakenWrong + CNT_W'(incNt);
    end
  end

endmodule

// File: rtl/exec_redirect_sel.sv
module exec_redirect_sel
  import exec_redirect_pkg::*;
#(
  parameter int THREADS    = 2,
  parameter int LANES      = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int CNT_W      = 16,
  parameter int INSN_BYTES = 4,
  parameter int TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [LANES-1:0]                  laneValid,
  input  logic [LANES-1:0][TID_W-1:0]       laneThread,
  input  logic [LANES-1:0]                  laneSquashed,
  input  logic [LANES-1:0][SEQ_W-1:0]       laneSeq,
  input  logic [LANES-1:0][PC_W-1:0]        lanePc,
  input  logic [LANES-1:0][PC_W-1:0]        laneNextPc,
  input  logic [LANES-1:0]                  lanePredTaken,
  input  logic [LANES-1:0]                  laneMispred,
  input  logic [THREADS-1:0]                violSet,
  input  logic [THREADS-1:0]                ldBlocked,
  output logic [THREADS-1:0]                recValid,
  output logic [THREADS-1:0][SEQ_W-1:0]     recSeq,
  output logic [THREADS-1:0][PC_W-1:0]      recTarget,
  output logic [THREADS-1:0][PC_W-1:0]      recMispPc,
  output logic [THREADS-1:0]                recBrMisp,
  output logic [THREADS-1:0]                recBrTaken,
  output logic [THREADS-1:0]                recInclSelf,
  output logic [CNT_W-1:0]                  cntTakenWrong,
  output logic [CNT_W-1:0]                  cntNotTakenWrong
);

  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  redirStrobe_t [THREADS-1:0]     strb;
  logic [THREADS-1:0][LSEL_W-1:0] laneSel;

  exec_redirect_ctrl #(
    .THREADS(THREADS), .LANES(LANES), .TID_W(TID_W), .LSEL_W(LSEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .laneValid(laneValid), .laneThread(laneThread),
    .laneSquashed(laneSquashed), .laneMispred(laneMispred),
    .violSet(violSet), .ldBlocked(ldBlocked),
    .strb(strb), .laneSel(laneSel)
  );

  exec_redirect_dp #(
    .THREADS(THREADS), .LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W),
    .CNT_W(CNT_W), .INSN_BYTES(INSN_BYTES), .LSEL_W(LSEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .laneSeq(laneSeq), .lanePc(lanePc), .laneNextPc(laneNextPc),
    .lanePredTaken(lanePredTaken),
    .strb(strb), .laneSel(laneSel),
    .recValid(recValid), .recSeq(recSeq), .recTarget(recTarget),
    .recMispPc(recMispPc), .recBrMisp(recBrMisp), .recBrTaken(recBrTaken),
    .recInclSelf(recInclSelf),
    .cntTakenWrong(cntTakenWrong), .cntNotTakenWrong(cntNotTakenWrong)
  );

endmodule

// File: rtl/exec_redirect_sel_chk.sv
module exec_redirect_sel_chk #(
  parameter int THREADS = 2,
  parameter int LANES   = 4,
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 16,
  parameter int TID_W   = 1
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [LANES-1:0]              laneValid,
  input logic [LANES-1:0][TID_W-1:0]   laneThread,
  input logic [LANES-1:0]              laneSquashed,
  input logic [LANES-1:0][SEQ_W-1:0]   laneSeq,
  input logic [LANES-1:0][PC_W-1:0]    laneNextPc,
  input logic [LANES-1:0]              laneMispred,
  input logic [THREADS-1:0]            recValid,
  input logic [THREADS-1:0][SEQ_W-1:0] recSeq,
  input logic [THREADS-1:0][PC_W-1:0]  recTarget,
  input logic [THREADS-1:0]            recBrMisp,
  input logic [THREADS-1:0]            recBrTaken,
  input logic [THREADS-1:0]            recInclSelf,
  input logic [CNT_W-1:0]              cntTakenWrong,
  input logic [CNT_W-1:0]              cntNotTakenWrong
);

  // R8: a group made only of squashed or empty lanes yields no record
  a_r8_squashed_silent: assert property (@(posedge clk) disable iff (!rstN)
    (&(laneSquashed | ~laneValid)) |=> (recValid == '0));

  // R9: counter growth equals the number of mispredict records this cycle
  a_r9_count_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (CNT_W'((cntTakenWrong + cntNotTakenWrong)
                     - $past(cntTakenWrong + cntNotTakenWrong))
              == CNT_W'($countones(recValid & recBrMisp))));

  for (genvar t = 0; t < THREADS; t++) begin : g_chk
    // R4: an unsquashed mispredict in the oldest lane always wins its thread
    a_r4_oldest_misp: assert property (@(posedge clk) disable iff (!rstN)
      (laneValid[0] && !laneSquashed[0] && laneMispred[0] &&
       laneThread[0] == TID_W'(t))
      |=> (recValid[t] && recBrMisp[t] && !recInclSelf[t] &&
           recSeq[t] == $past(laneSeq[0]) &&
           recTarget[t] == $past(laneNextPc[0])));

    // R5: the taken flag only accompanies a mispredict record
    a_r5_taken_needs_misp: assert property (@(posedge clk) disable iff (!rstN)
      recBrTaken[t] |-> (recValid[t] && recBrMisp[t]));

    // R7: include-self marks a blocked-load record, never a mispredict
    a_r7_incl_only_blk: assert property (@(posedge clk) disable iff (!rstN)
      recInclSelf[t] |-> (recValid[t] && !recBrMisp[t]));
  end

endmodule

bind exec_redirect_sel exec_redirect_sel_chk #(
  .THREADS(THREADS), .LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W),
  .CNT_W(CNT_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .laneValid(laneValid), .laneThread(laneThread),
  .laneSquashed(laneSquashed), .laneSeq(laneSeq), .laneNextPc(laneNextPc),
  .laneMispred(laneMispred), .recValid(recValid), .recSeq(recSeq),
  .recTarget(recTarget), .recBrMisp(recBrMisp), .recBrTaken(recBrTaken),
  .recInclSelf(recInclSelf), .cntTakenWrong(cntTakenWrong),
  .cntNotTakenWrong(cntNotTakenWrong)
);

// File: tb/exec_redirect_sel_test.sv
module exec_redirect_sel_test;

  localparam int CLK_PERIOD = 10;
  localparam int THREADS = 2;
  localparam int LANES   = 4;
  localparam int SEQ_W   = 16;
  localparam int PC_W    = 32;
  localparam int CNT_W   = 16;
  localparam int TID_W   = 1;

  logic clk = 1'b0;
  logic rstN;
  logic [LANES-1:0]                  laneValid;
  logic [LANES-1:0][TID_W-1:0]       laneThread;
  logic [LANES-1:0]                  laneSquashed;
  logic [LANES-1:0][SEQ_W-1:0]       laneSeq;
  logic [LANES-1:0][PC_W-1:0]        lanePc;
  logic [LANES-1:0][PC_W-1:0]        laneNextPc;
  logic [LANES-1:0]                  lanePredTaken;
  logic [LANES-1:0]                  laneMispred;
  logic [THREADS-1:0]                violSet;
  logic [THREADS-1:0]                ldBlocked;
  logic [THREADS-1:0]                recValid;
  logic [THREADS-1:0][SEQ_W-1:0]     recSeq;
  logic [THREADS-1:0][PC_W-1:0]      recTarget;
  logic [THREADS-1:0][PC_W-1:0]      recMispPc;
  logic [THREADS-1:0]                recBrMisp;
  logic [THREADS-1:0]                recBrTaken;
  logic [THREADS-1:0]                recInclSelf;
  logic [CNT_W-1:0]                  cntTakenWrong;
  logic [CNT_W-1:0]                  cntNotTakenWrong;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_redirect_sel #(
    .THREADS(THREADS), .LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)
  ) uut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clearLanes();
    laneValid = '0; laneThread = '0; laneSquashed = '0; laneSeq = '0;
    lanePc = '0; laneNextPc = '0; lanePredTaken = '0; laneMispred = '0;
  endtask

  task automatic setLane(int l, int tid, bit sq, int seq, int pc, int npc,
                         bit pt, bit mp);
    laneValid[l]     = 1'b1;
    laneThread[l]    = TID_W'(tid);
    laneSquashed[l]  = sq;
    laneSeq[l]       = SEQ_W'(seq);
    lanePc[l]        = PC_W'(pc);
    laneNextPc[l]    = PC_W'(npc);
    lanePredTaken[l] = pt;
    laneMispred[l]   = mp;
  endtask

  // Checks one thread's record; mispredict PC only for mispredict records.
  task automatic chkRec(int t, bit v, int seq, int tgt, int mpc, bit brm,
                        bit tk, bit incl, string tag);
    chk({tag, " valid"}, 64'(recValid[t]), 64'(v));
    if (v) begin
      chk({tag, " seq"},    64'(recSeq[t]),      64'(SEQ_W'(seq)));
      chk({tag, " target"}, 64'(recTarget[t]),   64'(PC_W'(tgt)));
      chk({tag, " brMisp"}, 64'(recBrMisp[t]),   64'(brm));
      chk({tag, " taken"},  64'(recBrTaken[t]),  64'(tk));
      chk({tag, " incl"},   64'(recInclSelf[t]), 64'(incl));
      if (brm) chk({tag, " mispPc"}, 64'(recMispPc[t]), 64'(PC_W'(mpc)));
    end
  endtask

  task automatic chkCnt(int tk, int nt, string tag);
    chk({tag, " cntTaken"},    64'(cntTakenWrong),    64'(tk));
    chk({tag, " cntNotTaken"}, 64'(cntNotTakenWrong), 64'(nt));
  endtask

  task automatic tReset();
    chk("R1 recValid", 64'(recValid), 64'(0));
    chkCnt(0, 0, "R1");
    tick();
    chk("R1 idle after reset", 64'(recValid), 64'(0));
  endtask

  task automatic tMispred();
    clearLanes();
    setLane(0, 1, 0, 19, 'h2F0, 'h2F4, 0, 0);
    setLane(1, 0, 0, 10, 'h100, 'h200, 0, 1);
    setLane(2, 0, 0, 11, 'h180, 'h280, 1, 1);
    setLane(3, 1, 0, 20, 'h300, 'h304, 1, 1);
    tick();
    chkRec(0, 1, 10, 'h200, 'h100, 1, 1, 0, "R4 R2 R5 thr0");
    chkRec(1, 1, 20, 'h304, 'h300, 1, 0, 0, "R4 R2 R5 thr1");
    chkCnt(1, 1, "R9 first");
    clearLanes();
    tick();
    chk("R10 one cycle", 64'(recValid), 64'(0));
  endtask

  task automatic tSquash();
    clearLanes();
    setLane(0, 0, 1, 30, 'h3F0, 'h800, 1, 1);
    setLane(1, 0, 0, 31, 'h400, 'h500, 0, 1);
    setLane(2, 1, 1, 32, 'h410, 'h900, 0, 1);
    tick();
    chkRec(0, 1, 31, 'h500, 'h400, 1, 1, 0, "R8 skip squashed");
    chk("R8 squashed only thread", 64'(recValid[1]), 64'(0));
    chkCnt(1, 2, "R9 R8 counts");
  endtask

  task automatic tViol();
    clearLanes();
    violSet = 2'b01;
    tick();
    violSet = '0;
    tick();
    chk("R11 pending without insn", 64'(recValid), 64'(0));
    setLane(0, 0, 0, 40, 'h600, 'h604, 0, 0);
    tick();
    chkRec(0, 1, 40, 'h604, 0, 0, 0, 0, "R6 R11 violation");
    clearLanes();
    setLane(0, 0, 0, 41, 'h604, 'h608, 0, 0);
    tick();
    chk("R6 consumed", 64'(recValid[0]), 64'(0));
  endtask

  task automatic tPrio();
    clearLanes();
    violSet = 2'b10;
    tick();
    violSet = '0;
    setLane(0, 1, 0, 50, 'h700, 'h800, 1, 1);
    tick();
    chkRec(1, 1, 50, 'h800, 'h700, 1, 1, 0, "R3 misp over viol");
    chkCnt(2, 2, "R9 taken");
    clearLanes();
    setLane(0, 1, 0, 51, 'h900, 'h904, 0, 0);
    tick();
    chkRec(1, 1, 51, 'h904, 0, 0, 0, 0, "R3 viol kept");
  endtask

  task automatic tBlocked();
    clearLanes();
    ldBlocked = 2'b01;
    violSet   = 2'b01;
    tick();
    chk("R7 needs insn", 64'(recValid), 64'(0));
    violSet = '0;
    setLane(0, 0, 0, 60, 'hA00, 'hA04, 0, 0);
    setLane(1, 0, 0, 61, 'hA04, 'hA08, 0, 0);
    tick();
    chkRec(0, 1, 60, 'hA04, 0, 0, 0, 0, "R3 R2 viol over blocked");
    clearLanes();
    setLane(0, 0, 0, 62, 'hB00, 'hB04, 0, 0);
    tick();
    chkRec(0, 1, 62, 'hB00, 0, 0, 0, 1, "R7 blocked load");
    clearLanes();
    setLane(0, 0, 0, 63, 'hB00, 'hB04, 0, 0);
    tick();
    chk("R7 handled", 64'(recValid[0]), 64'(0));
    clearLanes();
    ldBlocked = '0;
    tick();
    ldBlocked = 2'b01;
    setLane(0, 0, 0, 64, 'hC00, 'hC04, 0, 0);
    tick();
    chkRec(0, 1, 64, 'hC00, 0, 0, 0, 1, "R7 re-armed");
    clearLanes();
    ldBlocked = '0;
    tick();
    chkCnt(2, 2, "R9 final");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    violSet = '0;
    ldBlocked = '0;
    clearLanes();
    repeat (3) tick();
    rstN = 1'b1;
    tReset();
    tMispred();
    tSquash();
    tViol();
    tPrio();
    tBlocked();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule